// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the combinational control unit of a small single-cycle processor core that runs five instructions: register add without overflow trap, OR with immediate, word load, word store and branch on equal. It looks at the opcode field and the function field of the current instruction, plus the equality flag that the datapath raises when the two register reads match. From these it produces every steering signal the datapath needs. These are the destination register field select, the ALU second-operand source, the immediate extension mode, the ALU operation, memory write, load result select, register write and the next-PC source.

The decoder works in three stages. It first classifies the instruction. It then expands the class into a control word. Finally it gates the branch class with the equality flag, so that the PC mux select comes straight out of this block. Any encoding outside the supported set becomes a safe no-op: nothing is written to the register file or to memory, and the PC advances sequentially. The opcode and function codes are parameters, checked at elaboration to fit their fields and to be distinct. A parameter selects between a case-statement classifier and a parallel-match classifier, which produce the same result.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: Opcode 0x00 with function code 0x21 (register add) gives reg_dst_rd=1, alu_src_imm=0, ext_sign=0, alu_op=2'b00 (add), reg_wr=1, mem_wr=0, mem_to_reg=0, pc_branch=0.
- R2: Opcode 0x0D (OR immediate) gives reg_dst_rd=0, alu_src_imm=1, ext_sign=0 (zero-extend), alu_op=2'b01 (OR), reg_wr=1, mem_wr=0, mem_to_reg=0, pc_branch=0.
- R3: Opcode 0x23 (load word) gives reg_dst_rd=0, alu_src_imm=1, ext_sign=1, alu_op=2'b00 (add), mem_to_reg=1, reg_wr=1, mem_wr=0, pc_branch=0.
- R4: Opcode 0x2B (store word) gives alu_src_imm=1, ext_sign=1, alu_op=2'b00 (add), mem_wr=1, reg_wr=0, mem_to_reg=0, reg_dst_rd=0, pc_branch=0.
- R5: Opcode 0x04 (branch on equal) gives pc_branch equal to regs_equal, with reg_dst_rd=0, alu_src_imm=0, ext_sign=1, alu_op=2'b10 (subtract), reg_wr=0, mem_wr=0, mem_to_reg=0.
- R6: For every opcode other than 0x04, regs_equal has no effect on any output.
- R7: Any opcode outside {0x00, 0x04, 0x0D, 0x23, 0x2B} drives all single-bit outputs to 0 and alu_op to 2'b00.
- R8: Opcode 0x00 with any function code other than 0x21 gives the same all-zero no-op outputs as R7.
- R9: The function field has no effect on any output when the opcode is not 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary opcode field of the instruction |
| funct | input | 6 | Function field, decoded only for opcode 0x00 |
| regs_equal | input | 1 | Datapath flag: the two register read values are equal |
| reg_dst_rd | output | 1 | 1 selects the rd field as destination, 0 selects rt |
| alu_src_imm | output | 1 | 1 feeds the extended immediate to ALU input B, 0 the second register read |
| ext_sign | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends it |
| alu_op | output | 2 | ALU operation: 00 add, 01 OR, 10 subtract |
| mem_wr | output | 1 | Data memory write enable |
| mem_to_reg | output | 1 | 1 writes the memory read data to the register file, 0 the ALU result |
| reg_wr | output | 1 | Register file write enable |
| pc_branch | output | 1 | 1 selects the branch target as next PC, 0 selects PC + 4 |

## Verification
The block holds no state, so a wrong internal class or control word shows up on the ports in the same cycle the instruction fields are presented. A misclassified encoding appears as an unexpected write enable, a wrong extension mode or a wrong operand source. The bench sweeps every opcode across several function codes and both equality values, then adds seeded random instructions. Each output is compared with a table computed in the bench. It also checks that regs_equal and the function field have no effect outside the encodings that decode them.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;

   localparam int ALU_OP_W = 2;

   typedef enum logic [ALU_OP_W-1:0] {
      ALU_ADD = 2'b00,
      ALU_OR  = 2'b01,
      ALU_SUB = 2'b10
   } alu_op_e;

   typedef enum logic [2:0] {
      CLS_NOP  = 3'd0,
      CLS_ADDU = 3'd1,
      CLS_ORI  = 3'd2,
      CLS_LW   = 3'd3,
      CLS_SW   = 3'd4,
      CLS_BEQ  = 3'd5
   } instr_cls_e;

   typedef struct packed {
      logic    reg_dst_rd;
      logic    alu_src_imm;
      logic    ext_sign;
      alu_op_e alu_op;
      logic    mem_wr;
      logic    mem_to_reg;
      logic    reg_wr;
      logic    is_branch;
   } ctrl_word_t;

   localparam ctrl_word_t CTRL_NOP = '{
      reg_dst_rd:  1'b0,
      alu_src_imm: 1'b0,
      ext_sign:    1'b0,
      alu_op:      ALU_ADD,
      mem_wr:      1'b0,
      mem_to_reg:  1'b0,
      reg_wr:      1'b0,
      is_branch:   1'b0
   };

endpackage

// File: rtl/sc_ctrl_class_dec.sv
module sc_ctrl_class_dec
   import sc_ctrl_pkg::*;
#(
   parameter int          OP_W        = 6,
   parameter int          FN_W        = 6,
   parameter logic [OP_W-1:0] OPC_RTYPE = 6'h00,
   parameter logic [FN_W-1:0] FN_ADDU   = 6'h21,
   parameter logic [OP_W-1:0] OPC_ORI   = 6'h0D,
   parameter logic [OP_W-1:0] OPC_LW    = 6'h23,
   parameter logic [OP_W-1:0] OPC_SW    = 6'h2B,
   parameter logic [OP_W-1:0] OPC_BEQ   = 6'h04,
   parameter int          MATCH_STYLE = 0
) (
   input  logic [OP_W-1:0] opcode,
   input  logic [FN_W-1:0] funct,
   output instr_cls_e      cls
);

   localparam int N_LEGAL = 5;

   generate
      if (MATCH_STYLE == 1) begin : g_parallel
         logic [N_LEGAL-1:0] hit;
         assign hit[0] = (opcode == OPC_RTYPE) && (funct == FN_ADDU);
         assign hit[1] = (opcode == OPC_ORI);
         assign hit[2] = (opcode == OPC_LW);
         assign hit[3] = (opcode == OPC_SW);
         assign hit[4] = (opcode == OPC_BEQ);

         always_comb begin
            cls = CLS_NOP;
            if (hit[0]) cls = CLS_ADDU;
            if (hit[1]) cls = CLS_ORI;
            if (hit[2]) cls = CLS_LW;
            if (hit[3]) cls = CLS_SW;
            if (hit[4]) cls = CLS_BEQ;
         end
      end else begin : g_case
         always_comb begin
            cls = CLS_NOP;
            case (opcode)
               OPC_RTYPE: cls = (funct == FN_ADDU) ? CLS_ADDU : CLS_NOP;
               OPC_ORI:   cls = CLS_ORI;
               OPC_LW:    cls = CLS_LW;
               OPC_SW:    cls = CLS_SW;
               OPC_BEQ:   cls = CLS_BEQ;
               default:   cls = CLS_NOP;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/sc_ctrl_word_gen.sv
module sc_ctrl_word_gen
   import sc_ctrl_pkg::*;
(
   input  instr_cls_e cls,
   output ctrl_word_t word
);

   always_comb begin
      word = CTRL_NOP;
      case (cls)
         CLS_ADDU: begin
            word.reg_dst_rd = 1'b1;
            word.alu_op     = ALU_ADD;
            word.reg_wr     = 1'b1;
         end
         CLS_ORI: begin
            word.alu_src_imm = 1'b1;
            word.ext_sign    = 1'b0;
            word.alu_op      = ALU_OR;
            word.reg_wr      = 1'b1;
         end
         CLS_LW: begin
            word.alu_src_imm = 1'b1;
            word.ext_sign    = 1'b1;
            word.alu_op      = ALU_ADD;
            word.mem_to_reg  = 1'b1;
            word.reg_wr      = 1'b1;
         end
         CLS_SW: begin
            word.alu_src_imm = 1'b1;
            word.ext_sign    = 1'b1;
            word.alu_op      = ALU_ADD;
            word.mem_wr      = 1'b1;
         end
         CLS_BEQ: begin
            word.ext_sign  = 1'b1;
            word.alu_op    = ALU_SUB;
            word.is_branch = 1'b1;
         end
         default: word = CTRL_NOP;
      endcase
   end

endmodule

// File: rtl/sc_ctrl_branch_sel.sv
module sc_ctrl_branch_sel (
   input  logic is_branch,
   input  logic regs_equal,
   output logic pc_branch
);

   assign pc_branch = is_branch & regs_equal;

endmodule

// File: rtl/sc_ctrl_decoder.sv
module sc_ctrl_decoder
   import sc_ctrl_pkg::*;
#(
   parameter int          OP_W        = 6,
   parameter int          FN_W        = 6,
   parameter logic [OP_W-1:0] OPC_RTYPE = 6'h00,
   parameter logic [FN_W-1:0] FN_ADDU   = 6'h21,
   parameter logic [OP_W-1:0] OPC_ORI   = 6'h0D,
   parameter logic [OP_W-1:0] OPC_LW    = 6'h23,
   parameter logic [OP_W-1:0] OPC_SW    = 6'h2B,
   parameter logic [OP_W-1:0] OPC_BEQ   = 6'h04,
   parameter int          MATCH_STYLE = 0
) (
   input  logic [OP_W-1:0]     opcode,
   input  logic [FN_W-1:0]     funct,
   input  logic                regs_equal,
   output logic                reg_dst_rd,
   output logic                alu_src_imm,
   output logic                ext_sign,
   output logic [ALU_OP_W-1:0] alu_op,
   output logic                mem_wr,
   output logic                mem_to_reg,
   output logic                reg_wr,
   output logic                pc_branch
);

   generate
      if (OP_W < 1 || FN_W < 1) begin : g_bad_width
         $error("sc_ctrl_decoder: field widths must be positive");
      end
      if (MATCH_STYLE != 0 && MATCH_STYLE != 1) begin : g_bad_style
         $error("sc_ctrl_decoder: MATCH_STYLE must be 0 or 1");
      end
      if (OPC_RTYPE == OPC_ORI || OPC_RTYPE == OPC_LW || OPC_RTYPE == OPC_SW ||
          OPC_RTYPE == OPC_BEQ || OPC_ORI == OPC_LW || OPC_ORI == OPC_SW ||
          OPC_ORI == OPC_BEQ || OPC_LW == OPC_SW || OPC_LW == OPC_BEQ ||
          OPC_SW == OPC_BEQ) begin : g_bad_codes
         $error("sc_ctrl_decoder: opcode encodings must be distinct");
      end
   endgenerate

   instr_cls_e cls;
   ctrl_word_t word;

   sc_ctrl_class_dec #(
      .OP_W(OP_W), .FN_W(FN_W),
      .OPC_RTYPE(OPC_RTYPE), .FN_ADDU(FN_ADDU), .OPC_ORI(OPC_ORI),
      .OPC_LW(OPC_LW), .OPC_SW(OPC_SW), .OPC_BEQ(OPC_BEQ),
      .MATCH_STYLE(MATCH_STYLE)
   ) u_class (
      .opcode(opcode),
      .funct (funct),
      .cls   (cls)
   );

   sc_ctrl_word_gen u_word (
      .cls (cls),
      .word(word)
   );

   sc_ctrl_branch_sel u_branch (
      .is_branch (word.is_branch),
      .regs_equal(regs_equal),
      .pc_branch (pc_branch)
   );

   assign reg_dst_rd  = word.reg_dst_rd;
   assign alu_src_imm = word.alu_src_imm;
   assign ext_sign    = word.ext_sign;
   assign alu_op      = word.alu_op;
   assign mem_wr      = word.mem_wr;
   assign mem_to_reg  = word.mem_to_reg;
   assign reg_wr      = word.reg_wr;

endmodule

// File: rtl/sc_ctrl_decoder_chk.sv
module sc_ctrl_decoder_chk #(
   parameter int          OP_W      = 6,
   parameter int          FN_W      = 6,
   parameter logic [OP_W-1:0] OPC_RTYPE = 6'h00,
   parameter logic [FN_W-1:0] FN_ADDU   = 6'h21,
   parameter logic [OP_W-1:0] OPC_ORI   = 6'h0D,
   parameter logic [OP_W-1:0] OPC_LW    = 6'h23,
   parameter logic [OP_W-1:0] OPC_SW    = 6'h2B,
   parameter logic [OP_W-1:0] OPC_BEQ   = 6'h04
) (
   input logic [OP_W-1:0] opcode,
   input logic [FN_W-1:0] funct,
   input logic            regs_equal,
   input logic            reg_dst_rd,
   input logic            alu_src_imm,
   input logic            ext_sign,
   input logic [1:0]      alu_op,
   input logic            mem_wr,
   input logic            mem_to_reg,
   input logic            reg_wr,
   input logic            pc_branch
);

   logic known;
   logic legal_op;

   assign known    = !$isunknown({opcode, funct, regs_equal, reg_dst_rd, alu_src_imm,
                                  ext_sign, alu_op, mem_wr, mem_to_reg, reg_wr, pc_branch});
   assign legal_op = (opcode == OPC_RTYPE) || (opcode == OPC_ORI) || (opcode == OPC_LW) ||
                     (opcode == OPC_SW) || (opcode == OPC_BEQ);

   always_comb begin
      if (known) begin
         a_r1_rd_only_addu: assert (!reg_dst_rd ||
            (opcode == OPC_RTYPE && funct == FN_ADDU && reg_wr && !alu_src_imm))
            else $error("rd destination outside register add");
         a_r2_zero_ext_imm_is_or: assert (!(reg_wr && alu_src_imm && !ext_sign) ||
            (alu_op == 2'b01 && opcode == OPC_ORI))
            else $error("zero-extended immediate write not an OR");
         a_r3_load_select_writes: assert (!mem_to_reg ||
            (reg_wr && alu_src_imm && ext_sign && opcode == OPC_LW))
            else $error("memory result selected without a load");
         a_r4_store_no_regwrite: assert (!mem_wr ||
            (!reg_wr && alu_src_imm && opcode == OPC_SW))
            else $error("store with register write or wrong opcode");
         a_r5_branch_needs_equal: assert (!pc_branch ||
            (regs_equal && opcode == OPC_BEQ))
            else $error("branch taken without equality on branch opcode");
         a_r7_illegal_noop: assert (legal_op || (!reg_wr && !mem_wr && !pc_branch))
            else $error("unsupported opcode produced a side effect");
         a_r8_rtype_other_funct: assert (!(opcode == OPC_RTYPE && funct != FN_ADDU) ||
            (!reg_wr && !mem_wr && !pc_branch))
            else $error("unsupported function code produced a side effect");
      end
   end

endmodule

bind sc_ctrl_decoder sc_ctrl_decoder_chk #(
   .OP_W(OP_W), .FN_W(FN_W),
   .OPC_RTYPE(OPC_RTYPE), .FN_ADDU(FN_ADDU), .OPC_ORI(OPC_ORI),
   .OPC_LW(OPC_LW), .OPC_SW(OPC_SW), .OPC_BEQ(OPC_BEQ)
) u_chk (
   .opcode(opcode), .funct(funct), .regs_equal(regs_equal),
   .reg_dst_rd(reg_dst_rd), .alu_src_imm(alu_src_imm), .ext_sign(ext_sign),
   .alu_op(alu_op), .mem_wr(mem_wr), .mem_to_reg(mem_to_reg),
   .reg_wr(reg_wr), .pc_branch(pc_branch)
);

// File: tb/sc_ctrl_decoder_tb.sv
`timescale 1ns/1ps
module sc_ctrl_decoder_tb;

   logic       clk = 1'b0;
   logic [5:0] opcode = '0;
   logic [5:0] funct  = '0;
   logic       regs_equal = 1'b0;
   logic       reg_dst_rd, alu_src_imm, ext_sign, mem_wr, mem_to_reg, reg_wr, pc_branch;
   logic [1:0] alu_op;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   sc_ctrl_decoder u_dut (
      .opcode(opcode), .funct(funct), .regs_equal(regs_equal),
      .reg_dst_rd(reg_dst_rd), .alu_src_imm(alu_src_imm), .ext_sign(ext_sign),
      .alu_op(alu_op), .mem_wr(mem_wr), .mem_to_reg(mem_to_reg),
      .reg_wr(reg_wr), .pc_branch(pc_branch)
   );

   // Packed order: reg_dst_rd, alu_src_imm, ext_sign, alu_op[1:0], mem_wr, mem_to_reg, reg_wr, pc_branch
   function automatic logic [8:0] expect_ctrl(input logic [5:0] op, input logic [5:0] fn,
                                              input logic eq);
      case (op)
         6'h00:   return (fn == 6'h21) ? 9'b1_0_0_00_0_0_1_0 : 9'b0;
         6'h0D:   return 9'b0_1_0_01_0_0_1_0;
         6'h23:   return 9'b0_1_1_00_0_1_1_0;
         6'h2B:   return 9'b0_1_1_00_1_0_0_0;
         6'h04:   return {8'b0_0_1_10_0_0_0, eq};
         default: return 9'b0;
      endcase
   endfunction

   function automatic string tag_for(input logic [5:0] op, input logic [5:0] fn);
      case (op)
         6'h00:   return (fn == 6'h21) ? "R1" : "R8";
         6'h0D:   return "R2";
         6'h23:   return "R3";
         6'h2B:   return "R4";
         6'h04:   return "R5";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [8:0] observed();
      return {reg_dst_rd, alu_src_imm, ext_sign, alu_op, mem_wr, mem_to_reg, reg_wr, pc_branch};
   endfunction

   task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic eq);
      @(posedge clk);
      opcode     <= op;
      funct      <= fn;
      regs_equal <= eq;
      @(negedge clk);
   endtask

   task automatic compare(input logic [8:0] act, input logic [8:0] exp, input string tag,
                          input logic [5:0] op, input logic [5:0] fn, input logic eq);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s op=%02h fn=%02h eq=%0b actual=%09b expected=%09b",
                  tag, op, fn, eq, act, exp);
      end
   endtask

   task automatic check(input logic [5:0] op, input logic [5:0] fn, input logic eq,
                        input string tag);
      apply(op, fn, eq);
      compare(observed(), expect_ctrl(op, fn, eq), tag, op, fn, eq);
   endtask

   initial begin
      logic [8:0] first;
      logic [8:0] ref_word;
      logic [5:0] legal [5];
      legal[0] = 6'h00; legal[1] = 6'h0D; legal[2] = 6'h23;
      legal[3] = 6'h2B; legal[4] = 6'h04;

      // Idle state: all-zero fields decode as R-type with unsupported funct (R8 no-op)
      @(negedge clk);
      compare(observed(), 9'b0, "R8", 6'h00, 6'h00, 1'b0);

      // Directed: each supported encoding with both equality values
      check(6'h00, 6'h21, 1'b0, "R1");
      check(6'h00, 6'h21, 1'b1, "R1");
      check(6'h0D, 6'h00, 1'b0, "R2");
      check(6'h23, 6'h00, 1'b1, "R3");
      check(6'h2B, 6'h00, 1'b1, "R4");
      check(6'h04, 6'h00, 1'b0, "R5");
      check(6'h04, 6'h00, 1'b1, "R5");
      check(6'h04, 6'h3F, 1'b1, "R5");

      // R8: neighbouring function codes
      check(6'h00, 6'h20, 1'b0, "R8");
      check(6'h00, 6'h23, 1'b1, "R8");
      check(6'h00, 6'h01, 1'b1, "R8");

      // Sweep every opcode over several funct values and both flags
      for (int op = 0; op < 64; op++) begin
         for (int k = 0; k < 4; k++) begin
            logic [5:0] fn;
            fn = (k == 0) ? 6'h21 : (k == 1) ? 6'h00 : (k == 2) ? 6'h3F : 6'h15;
            for (int e = 0; e < 2; e++)
               check(6'(op), fn, 1'(e), tag_for(6'(op), fn));
         end
      end

      // R6: flag ignored away from the branch opcode
      for (int op = 0; op < 64; op++) begin
         if (op != 6'h04) begin
            apply(6'(op), 6'h21, 1'b0);
            first = observed();
            apply(6'(op), 6'h21, 1'b1);
            compare(observed(), first, "R6", 6'(op), 6'h21, 1'b1);
         end
      end

      // R9: funct ignored when opcode is not R-type
      for (int i = 1; i < 5; i++) begin
         apply(legal[i], 6'h00, 1'b1);
         ref_word = observed();
         for (int fn = 1; fn < 64; fn += 7) begin
            apply(legal[i], 6'(fn), 1'b1);
            compare(observed(), ref_word, "R9", legal[i], 6'(fn), 1'b1);
         end
      end

      // Seeded random mix, half biased to supported encodings
      void'($urandom(32'h5EED_C0DE));
      for (int n = 0; n < 400; n++) begin
         logic [5:0] op;
         logic [5:0] fn;
         logic       eq;
         op = ($urandom % 2 == 0) ? legal[$urandom % 5] : 6'($urandom);
         fn = ($urandom % 3 == 0) ? 6'h21 : 6'($urandom);
         eq = 1'($urandom);
         check(op, fn, eq, tag_for(op, fn));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule